// File: doc/BRIEF.md
# Per-Pin Digital Input Glitch Filter

This block cleans up noisy digital inputs for a 32-pin port before they reach the edge and level detector that raises pin interrupts. Every pin has its own filter, and each filter can be switched on or off by itself. All filters share two settings: the sampling source and the filter length. The sampling source is either every bus clock cycle or a slow tick of about 1 kHz. The tick arrives as a single-cycle enable pulse in the bus clock domain. The filter length is a 5-bit value.

A filtered output follows its raw input only after the input has held a new level for length+1 consecutive samples. If the input returns to the current output level before then, the count starts again from zero. A filter that is switched off, or whose pin is not set up as a digital input, holds its output at 0. Software writes three word-addressed registers: per-pin enables, the filter length and the sampling source. Any write to the length or the source register restarts every counter.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, every filtered output is 0 and the enable, length and source registers all read 0.
- R2: Bit n of the enable register (word address 0) turns on the filter for pin n. When that bit is 0, the output of pin n is 0 from the second clock edge after the bit was cleared.
- R3: A pin whose digital-input qualifier is low has its filtered output forced to 0, whatever its raw input.
- R4: When a filter is active, its output changes to a new level only after the raw input has differed from the output for length+1 consecutive samples. With length 0 the change happens at the first sample. The per-pin counter never exceeds the programmed length.
- R5: If the raw input returns to the current output level while a count is running, the count restarts from zero.
- R6: The length register is at word address 1. Its value sits in bits 4:0 and all higher bits read 0. The source register is at word address 2 and only bit 0 is kept. Word address 3 reads 0. The enable register reads back all 32 bits.
- R7: When source bit 0 is 0, the filters sample on every bus clock. When it is 1, they sample only in cycles where the slow tick pulse is high. Between samples the outputs do not change.
- R8: Any write to the length register or the source register clears every filter counter at that clock edge, even if the written value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 enable, 1 length, 2 source |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| slow_tick | input | 1 | Single-cycle pulse of the slow sampling source |
| pin_is_din | input | 32 | Per-pin qualifier: pin is set up as a digital input |
| pin_in | input | 32 | Raw pin levels, synchronous to clk |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
Each kind of wrong counter state shows up at the ports. A counter that is not cleared, or that skips a sample, makes pin_filt switch one or more samples early or late. A restart that fails makes it switch too soon after a length write. A strobe selection that is wrong makes outputs move between slow ticks. Each of these is seen within length+2 samples of the stimulus. A wrong enable or qualifier path leaves a stale 1 on pin_filt one cycle after the control bit drops. A register defect appears at once on reg_rdata.

// File: rtl/glf_pkg.sv
package glf_pkg;

   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      A_ENABLE = 2'd0,
      A_LENGTH = 2'd1,
      A_SOURCE = 2'd2,
      A_SPARE  = 2'd3
   } reg_addr_e;

   typedef enum logic {
      SRC_BUS  = 1'b0,
      SRC_SLOW = 1'b1
   } clk_src_e;

endpackage

// File: rtl/glf_regs.sv
module glf_regs
   import glf_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   output logic [NUM_PINS-1:0] reg_rdata,
   output logic [NUM_PINS-1:0] en_q,
   output logic [LEN_W-1:0]    len_q,
   output clk_src_e            src_q,
   output logic                cfg_restart
);

   if (LEN_W < 1 || LEN_W > NUM_PINS) begin : g_bad_len
      $error("glf_regs: LEN_W must be between 1 and NUM_PINS");
   end

   logic wr_en, wr_len, wr_src;

   assign wr_en  = reg_wr && (reg_addr == A_ENABLE);
   assign wr_len = reg_wr && (reg_addr == A_LENGTH);
   assign wr_src = reg_wr && (reg_addr == A_SOURCE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         len_q <= '0;
         src_q <= SRC_BUS;
      end else begin
         if (wr_en)  en_q  <= reg_wdata;
         if (wr_len) len_q <= reg_wdata[LEN_W-1:0];
         if (wr_src) src_q <= clk_src_e'(reg_wdata[0]);
      end
   end

   // a configuration write restarts counters at the same edge
   assign cfg_restart = wr_len || wr_src;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_ENABLE: reg_rdata = en_q;
         A_LENGTH: reg_rdata[LEN_W-1:0] = len_q;
         A_SOURCE: reg_rdata[0] = src_q;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/glf_strobe.sv
module glf_strobe
   import glf_pkg::*;
#(
   parameter bit HAS_SLOW_SRC = 1'b1
) (
   input  clk_src_e src_q,
   input  logic     slow_tick,
   output logic     sample_en
);

   if (HAS_SLOW_SRC) begin : g_sel
      assign sample_en = (src_q == SRC_SLOW) ? slow_tick : 1'b1;
   end else begin : g_bus_only
      logic unused_src;
      assign unused_src = (src_q == SRC_SLOW) ^ slow_tick;
      assign sample_en  = 1'b1 | unused_src;
   end

endmodule

// File: rtl/glf_cell.sv
module glf_cell #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             sample,
   input  logic             restart,
   input  logic             din,
   input  logic [LEN_W-1:0] len,
   output logic             dout,
   output logic [LEN_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= 1'b0;
         cnt  <= '0;
      end else if (!active) begin
         dout <= 1'b0;
         cnt  <= '0;
      end else if (restart) begin
         cnt  <= '0;
      end else if (din == dout) begin
         cnt  <= '0;
      end else if (sample) begin
         if (cnt >= len) begin
            dout <= din;
            cnt  <= '0;
         end else begin
            cnt  <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
   import glf_pkg::*;
#(
   parameter int NUM_PINS     = 32,
   parameter int LEN_W        = 5,
   parameter bit HAS_SLOW_SRC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   output logic [NUM_PINS-1:0] reg_rdata,
   input  logic                slow_tick,
   input  logic [NUM_PINS-1:0] pin_is_din,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_filt
);

   localparam int CNT_BITS = NUM_PINS * LEN_W;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("pin_glitch_filter: NUM_PINS must be at least 1");
   end

   logic [NUM_PINS-1:0] en_q;
   logic [LEN_W-1:0]    len_q;
   clk_src_e            src_q;
   logic                cfg_restart;
   logic                sample_en;
   logic [CNT_BITS-1:0] cnt_all;

   glf_regs #(.NUM_PINS(NUM_PINS), .LEN_W(LEN_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .en_q       (en_q),
      .len_q      (len_q),
      .src_q      (src_q),
      .cfg_restart(cfg_restart)
   );

   glf_strobe #(.HAS_SLOW_SRC(HAS_SLOW_SRC)) u_strobe (
      .src_q    (src_q),
      .slow_tick(slow_tick),
      .sample_en(sample_en)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      glf_cell #(.LEN_W(LEN_W)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (en_q[i] & pin_is_din[i]),
         .sample (sample_en),
         .restart(cfg_restart),
         .din    (pin_in[i]),
         .len    (len_q),
         .dout   (pin_filt[i]),
         .cnt    (cnt_all[i*LEN_W +: LEN_W])
      );
   end

endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk
   import glf_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int LEN_W    = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_wr,
   input logic [REG_AW-1:0]           reg_addr,
   input logic [NUM_PINS-1:0]         reg_rdata,
   input logic [NUM_PINS-1:0]         pin_is_din,
   input logic [NUM_PINS-1:0]         pin_filt,
   input logic [NUM_PINS-1:0]         en_q,
   input logic [LEN_W-1:0]            len_q,
   input logic                        sample_en,
   input logic [NUM_PINS*LEN_W-1:0]   cnt_all
);

   if (LEN_W < NUM_PINS) begin : g_rsv
      AST_LEN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_addr == A_LENGTH) |-> (reg_rdata[NUM_PINS-1:LEN_W] == '0)); // R6
   end

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == A_LENGTH || reg_addr == A_SOURCE)) |=> (cnt_all == '0)); // R8

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[i] |=> !pin_filt[i]); // R2
      AST_NOT_INPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_is_din[i] |=> !pin_filt[i]); // R3
      AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] && pin_is_din[i] && !sample_en) |=> $stable(pin_filt[i])); // R7
      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_all[i*LEN_W +: LEN_W] <= len_q); // R4
      AST_CHANGE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(pin_filt[i]) || ($fell(pin_filt[i]) && $past(en_q[i] && pin_is_din[i])))
         |-> $past(cnt_all[i*LEN_W +: LEN_W] == len_q)); // R4
   end

endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(.NUM_PINS(NUM_PINS), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .pin_is_din(pin_is_din),
   .pin_filt  (pin_filt),
   .en_q      (en_q),
   .len_q     (len_q),
   .sample_en (sample_en),
   .cnt_all   (cnt_all)
);

// File: tb/tb_pin_glitch_filter.sv
`timescale 1ns/1ps
module tb_pin_glitch_filter;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic          slow_tick = 1'b0;
   logic [N-1:0]  pin_is_din = '1;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_filt;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pin_glitch_filter dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_tick(slow_tick),
      .pin_is_din(pin_is_din), .pin_in(pin_in), .pin_filt(pin_filt)
   );

   // {low-byte input, expected low-byte output}, length 2, bus sampling
   localparam logic [15:0] VEC [18] = '{
      16'h01_00, 16'h01_00, 16'h01_01, 16'h03_01, 16'h01_01, 16'h03_01,
      16'h03_01, 16'h03_03, 16'hF0_03, 16'hF0_03, 16'hF0_F0, 16'h0F_F0,
      16'h0F_F0, 16'hF0_F0, 16'hF0_F0, 16'h00_F0, 16'h00_F0, 16'h00_00
   };

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
      reg_addr = a;
      #0.5;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      pin_in = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R1 output in reset", pin_filt, '0);
      rst_n = 1'b1;
      step();
      chk("R1 output after reset", pin_filt, '0);
      rd(2'd0, '0, "R1 enable reset");
      rd(2'd1, '0, "R1 length reset");
      rd(2'd2, '0, "R1 source reset");

      pin_in = 32'hFFFF_FF00;
      wr(2'd0, 32'h0000_00FF);
      wr(2'd1, 32'd2);
      rd(2'd0, 32'h0000_00FF, "R6 enable readback");

      // table: R4 length+1 samples, R5 restart on return, R2 upper pins disabled
      for (int k = 0; k < 18; k++) begin
         pin_in = {24'hFF_FFFF, VEC[k][15:8]};
         step();
         chk($sformatf("R4/R5/R2 vector %0d", k), pin_filt, {24'h0, VEC[k][7:0]});
      end

      // R4: length 0 passes at the first sample
      wr(2'd1, 32'd0);
      pin_in = {24'hFF_FFFF, 8'h01};
      step();
      chk("R4 length zero", pin_filt, 32'h1);

      // R2: clearing enable forces zero
      wr(2'd0, 32'h0000_00FE);
      step();
      chk("R2 disable forces zero", pin_filt, 32'h0);

      // R3: not a digital input forces zero
      pin_is_din[1] = 1'b0;
      pin_in = {24'hFF_FFFF, 8'h03};
      step();
      chk("R3 qualifier low", pin_filt, 32'h0);
      pin_is_din[1] = 1'b1;
      step();
      chk("R3 qualifier restored", pin_filt, 32'h2);
      wr(2'd0, 32'h0000_00FF);
      step();
      chk("R2 re-enable", pin_filt, 32'h3);

      // R7: slow tick sampling, length 1
      wr(2'd1, 32'd1);
      wr(2'd2, 32'd1);
      pin_in = {24'hFF_FFFF, 8'h00};
      repeat (3) step();
      chk("R7 no tick holds", pin_filt, 32'h3);
      slow_tick = 1'b1; step(); slow_tick = 1'b0;
      chk("R7 first tick", pin_filt, 32'h3);
      repeat (2) step();
      chk("R7 between ticks", pin_filt, 32'h3);
      slow_tick = 1'b1; step(); slow_tick = 1'b0;
      chk("R7 second tick", pin_filt, 32'h0);

      // R6: reserved bits and spare address
      wr(2'd1, 32'hFFFF_FFE3);
      rd(2'd1, 32'h3, "R6 length reserved bits");
      rd(2'd3, 32'h0, "R6 spare address");
      wr(2'd2, 32'hFFFF_FFFE);
      rd(2'd2, 32'h0, "R6 source bit0 only");

      // R8: length write restarts the count (length 3)
      pin_in = {24'hFF_FFFF, 8'h01};
      repeat (2) step();
      wr(2'd1, 32'd3);
      repeat (3) step();
      chk("R8 restart delays change", pin_filt, 32'h0);
      step();
      chk("R8 change after full count", pin_filt, 32'h1);

      // R1: reset mid-run
      rst_n = 1'b0;
      #0.5;
      chk("R1 async reset output", pin_filt, '0);
      rd(2'd0, '0, "R1 enable cleared");
      rd(2'd1, '0, "R1 length cleared");

      done = 1'b1;
      finish_run();
   end

endmodule